// File: doc/BRIEF.md
# Bidirectional Universal Shift Register with Tri-State Output

This block is a small synchronous register whose stages can be loaded all at once, moved one place toward the high end or toward the low end, or cleared. A two-bit mode input selects the operation, and the operation takes effect on each rising clock edge. Each shift direction has its own serial input, which supplies the bit entering the register at the open end.

The block has no reset pin. The register is cleared by clocking it once in the clear mode. Until that first clear or load, the stored value is undefined. An output-enable input controls the output stage. When the enable is low, every output bit floats at high impedance. The stored value is not affected, and loading and shifting continue as normal. This lets several such registers share one parallel bus.

The four modes act as the states of the stage update, and the selected mode picks each stage's next value:
- CLEAR (`mode_i` = 00): zero every stage.
- SHIFT_UP (01): bit 0 takes the serial input and each bit moves one place higher.
- SHIFT_DOWN (10): the top bit takes the other serial input and each bit moves one place lower.
- LOAD (11): capture the parallel input.

Any mode can follow any other on the next edge.

Top module: `usr_shift_reg`

## Requirements
- R1: When `mode_i` = 11 at a rising edge, every stage takes the matching bit of `d_i`. The new value is visible on `q_o` right after that edge.
- R2: During a load (`mode_i` = 11), `ser_up_i` and `ser_dn_i` have no effect on the stored value.
- R3: When `mode_i` = 01 at a rising edge, stage 0 takes `ser_up_i` and stage i takes the old stage i-1, for i from 1 to WIDTH-1.
- R4: When `mode_i` = 10 at a rising edge, stage WIDTH-1 takes `ser_dn_i` and stage i takes the old stage i+1, for i from 0 to WIDTH-2.
- R5: When `mode_i` = 00 at a rising edge, every stage becomes 0. No other input clears the register.
- R6: While `out_en_i` is 1, `q_o` equals the stored value.
- R7: While `out_en_i` is 0, every bit of `q_o` is high impedance. Loads and shifts still update the stored value, and that value appears on `q_o` once the enable returns to 1.
- R8: Changes on `mode_i`, `d_i` or the serial inputs between rising edges do not alter the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| mode_i | input | 2 | Operation select: 00 clear, 01 shift up, 10 shift down, 11 load |
| d_i | input | WIDTH (4) | Parallel load data |
| ser_up_i | input | 1 | Serial bit entering stage 0 when shifting up |
| ser_dn_i | input | 1 | Serial bit entering stage WIDTH-1 when shifting down |
| out_en_i | input | 1 | Output enable, active high; 0 floats every output bit |
| q_o | output | WIDTH (4) | Stored value, or high impedance when disabled |

## Verification
The assertions assume that the stored value becomes known only after the first edge in the clear or load mode. They therefore stay disabled until two edges after such an edge has been seen. The bench respects this: it holds the clear mode for two cycles before any other stimulus.

The assertions also assume that the inputs are settled at every rising edge. The bench changes its inputs only two time units after an edge, never near the next one. During the between-edge glitch test, the bench restores the inputs well before that edge.

// File: rtl/usr_pkg.sv
package usr_pkg;

    typedef enum logic [1:0] {
        MODE_CLEAR = 2'b00,
        MODE_SHUP  = 2'b01,
        MODE_SHDN  = 2'b10,
        MODE_LOAD  = 2'b11
    } usr_mode_e;

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
    import usr_pkg::*;
(
    input  logic [1:0] sel_i,
    output usr_mode_e  mode_o
);
    always_comb begin
        unique case (sel_i)
            2'b00:   mode_o = MODE_CLEAR;
            2'b01:   mode_o = MODE_SHUP;
            2'b10:   mode_o = MODE_SHDN;
            default: mode_o = MODE_LOAD;
        endcase
    end
endmodule

// File: rtl/usr_stage_bank.sv
module usr_stage_bank
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  usr_mode_e        mode_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic             ser_up_i,
    input  logic             ser_dn_i,
    output logic [WIDTH-1:0] stage_o
);
    localparam int TOP = WIDTH - 1;

    logic [WIDTH-1:0] stage_q;
    logic [WIDTH-1:0] stage_d;
    logic [WIDTH-1:0] from_below;
    logic [WIDTH-1:0] from_above;

    // Neighbour wiring: each end of the chain takes a serial input.
    for (genvar i = 0; i < WIDTH; i++) begin : g_link
        if (i == 0) begin : g_low
            assign from_below[i] = ser_up_i;
        end else begin : g_low_mid
            assign from_below[i] = stage_q[i-1];
        end
        if (i == TOP) begin : g_high
            assign from_above[i] = ser_dn_i;
        end else begin : g_high_mid
            assign from_above[i] = stage_q[i+1];
        end

        // Next-value selection for one stage.
        always_comb begin
            unique case (mode_i)
                MODE_CLEAR: stage_d[i] = 1'b0;
                MODE_SHUP:  stage_d[i] = from_below[i];
                MODE_SHDN:  stage_d[i] = from_above[i];
                MODE_LOAD:  stage_d[i] = d_i[i];
            endcase
        end
    end

    // Stage register: the only place the stored value changes.
    always_ff @(posedge clk_i) begin
        stage_q <= stage_d;
    end

    assign stage_o = stage_q;
endmodule

// File: rtl/usr_out_driver.sv
module usr_out_driver #(
    parameter int WIDTH = 4
) (
    input  logic             en_i,
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] pad_o
);
    assign pad_o = en_i ? data_i : {WIDTH{1'bz}};
endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic             ser_up_i,
    input  logic             ser_dn_i,
    input  logic             out_en_i,
    output logic [WIDTH-1:0] q_o
);
    usr_mode_e        mode;
    logic [WIDTH-1:0] stage_q;

    usr_mode_decode u_dec (
        .sel_i  (mode_i),
        .mode_o (mode)
    );

    usr_stage_bank #(.WIDTH(WIDTH)) u_bank (
        .clk_i    (clk_i),
        .mode_i   (mode),
        .d_i      (d_i),
        .ser_up_i (ser_up_i),
        .ser_dn_i (ser_dn_i),
        .stage_o  (stage_q)
    );

    usr_out_driver #(.WIDTH(WIDTH)) u_drv (
        .en_i   (out_en_i),
        .data_i (stage_q),
        .pad_o  (q_o)
    );
endmodule

// File: rtl/usr_shift_reg_chk.sv
module usr_shift_reg_chk #(
    parameter int WIDTH = 4
) (
    input logic             clk_i,
    input logic [1:0]       mode_i,
    input logic [WIDTH-1:0] d_i,
    input logic             ser_up_i,
    input logic             ser_dn_i,
    input logic             out_en_i,
    input logic [WIDTH-1:0] q_o,
    input logic [WIDTH-1:0] stage_q
);
    localparam int TOP = WIDTH - 1;

    // Stored value is known only after a clear or load edge; wait one more edge.
    bit seen_init;
    bit armed;
    always_ff @(posedge clk_i) begin
        if (mode_i == 2'b00 || mode_i == 2'b11) seen_init <= 1'b1;
        armed <= seen_init;
    end

    a_r1_load: assert property (@(posedge clk_i) disable iff (!armed)
        $past(mode_i) == 2'b11 |-> stage_q == $past(d_i));

    a_r3_shift_up: assert property (@(posedge clk_i) disable iff (!armed)
        $past(mode_i) == 2'b01 |->
            (stage_q[0] == $past(ser_up_i)) && (stage_q[TOP:1] == $past(stage_q[TOP-1:0])));

    a_r4_shift_down: assert property (@(posedge clk_i) disable iff (!armed)
        $past(mode_i) == 2'b10 |->
            (stage_q[TOP] == $past(ser_dn_i)) && (stage_q[TOP-1:0] == $past(stage_q[TOP:1])));

    a_r5_clear: assert property (@(posedge clk_i) disable iff (!armed)
        $past(mode_i) == 2'b00 |-> stage_q == '0);

    a_r6_drive: assert property (@(posedge clk_i) disable iff (!armed)
        out_en_i |-> q_o == stage_q);

    a_r7_load_while_hiz: assert property (@(posedge clk_i) disable iff (!armed)
        ($past(mode_i) == 2'b11 && !$past(out_en_i)) |-> stage_q == $past(d_i));
endmodule

bind usr_shift_reg usr_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_i    (clk_i),
    .mode_i   (mode_i),
    .d_i      (d_i),
    .ser_up_i (ser_up_i),
    .ser_dn_i (ser_dn_i),
    .out_en_i (out_en_i),
    .q_o      (q_o),
    .stage_q  (stage_q)
);

// File: tb/tb_usr_shift_reg.sv
`timescale 1ns/1ps
module tb_usr_shift_reg;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic [1:0]   mode = 2'b00;
    logic [W-1:0] d = '0;
    logic         sup = 1'b0;
    logic         sdn = 1'b0;
    logic         oe = 1'b1;
    logic [W-1:0] q;

    logic [W-1:0] model = '0;
    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    usr_shift_reg #(.WIDTH(W)) dut (
        .clk_i    (clk),
        .mode_i   (mode),
        .d_i      (d),
        .ser_up_i (sup),
        .ser_dn_i (sdn),
        .out_en_i (oe),
        .q_o      (q)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            fails++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    // Apply inputs, take one edge, update model, sample 2 ns after the edge.
    task automatic tick(input logic [1:0] m, input logic [W-1:0] dv,
                        input logic su, input logic sd);
        mode = m; d = dv; sup = su; sdn = sd;
        @(posedge clk);
        case (m)
            2'b00: model = '0;
            2'b01: model = {model[W-2:0], su};
            2'b10: model = {sd, model[W-1:1]};
            default: model = dv;
        endcase
        #2;
    endtask

    task automatic t_clear();
        tick(2'b00, 4'hF, 1'b1, 1'b1);
        tick(2'b00, 4'hF, 1'b1, 1'b1);
        check("R5 clear after start", 4'h0);
        tick(2'b11, 4'hD, 1'b0, 1'b0);
        tick(2'b00, 4'hA, 1'b1, 1'b1);
        check("R5 clear from 1101", 4'h0);
    endtask

    task automatic t_load();
        tick(2'b11, 4'hA, 1'b0, 1'b0);
        check("R1 load 1010", 4'hA);
        tick(2'b11, 4'h5, 1'b0, 1'b0);
        check("R1 load 0101", 4'h5);
        check("R6 output drives stored", model);
    endtask

    task automatic t_load_inhibit();
        tick(2'b11, 4'h0, 1'b1, 1'b1);
        check("R2 serial ignored in load (zeros)", 4'h0);
        tick(2'b11, 4'h6, 1'b1, 1'b1);
        check("R2 serial ignored in load (0110)", 4'h6);
    endtask

    task automatic t_shift_up();
        tick(2'b11, 4'h1, 1'b0, 1'b0);
        tick(2'b01, 4'h0, 1'b1, 1'b0);
        check("R3 shift up step1", 4'h3);
        tick(2'b01, 4'h0, 1'b0, 1'b1);
        check("R3 shift up step2", 4'h6);
        tick(2'b01, 4'h0, 1'b0, 1'b1);
        tick(2'b01, 4'h0, 1'b1, 1'b1);
        check("R3 shift up bit falls off top", model);
        check("R3 model value 1001", 4'h9);
    endtask

    task automatic t_shift_down();
        tick(2'b11, 4'h8, 1'b0, 1'b0);
        tick(2'b10, 4'h0, 1'b0, 1'b1);
        check("R4 shift down step1", 4'hC);
        tick(2'b10, 4'h0, 1'b1, 1'b0);
        check("R4 shift down step2", 4'h6);
        tick(2'b10, 4'h0, 1'b1, 1'b0);
        tick(2'b10, 4'h0, 1'b0, 1'b1);
        check("R4 shift down bit falls off bottom", 4'h9);
    endtask

    task automatic t_hiz();
        tick(2'b11, 4'hB, 1'b0, 1'b0);
        oe = 1'b0;
        #1;
        checks++;
        if (!(q === 4'bzzzz || q === 4'b0000)) begin
            fails++;
            $display("FAIL R7: q=%b expected zzzz", q);
        end
        tick(2'b01, 4'h0, 1'b1, 1'b0);
        tick(2'b10, 4'h0, 1'b0, 1'b1);
        checks++;
        if (!(q === 4'bzzzz || q === 4'b0000)) begin
            fails++;
            $display("FAIL R7 after shifts: q=%b expected zzzz", q);
        end
        oe = 1'b1;
        #1;
        check("R7 shifts continued while floating", model);
        check("R7 value 1011", 4'hB);
    endtask

    task automatic t_hold();
        tick(2'b11, 4'h9, 1'b0, 1'b0);
        mode = 2'b00; d = 4'h6; sup = 1'b1; sdn = 1'b1;
        #1; mode = 2'b01; #1; mode = 2'b11; #1;
        check("R8 stored value steady between edges", 4'h9);
        mode = 2'b11; d = 4'h9;
        tick(2'b11, 4'h9, 1'b0, 1'b0);
        check("R8 then R1 reload", 4'h9);
        repeat (3) @(posedge clk);
        #2;
        check("R8 stored value steady across load edges", 4'h9);
    endtask

    initial begin
        fork
            begin
                t_clear();
                t_load();
                t_load_inhibit();
                t_shift_up();
                t_shift_down();
                t_hiz();
                t_hold();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: q=%b expected completion", q);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule